// File: doc/BRIEF.md
# Scanline-Driven CHR Half Switcher

This block is the register and bank-selection core of a cartridge mapper. The CPU writes four 8-bit control registers through an address window at 0x5000 to 0x53FF. Two address bits inside that window pick which register takes the data. From these registers, and from an outer bank offset supplied by a surrounding multi-mode board, the block forms the number of the 32 KB program bank.

The block can also change the character pattern mapping partway down each frame without any help from software. A register bit enables a split mode. The video side pulses a strobe at the start of every scanline and presents the number of that line. While split mode is on, both 4 KB pattern halves use bank 0 in the upper part of the picture. From a fixed middle line onward they both use bank 1. Near the bottom of the frame, and whenever split mode is off, the pattern space falls back to one linear 8 KB bank 0, which means the lower half uses 4 KB bank 0 and the upper half uses 4 KB bank 1.

A mode-activation clear input sets all four registers to zero. The nametable mirroring output follows a single configuration bit from the outer board.

Top module: `scanline_chr_mapper`

## Requirements
- R1: A CPU write whose address lies in 0x5000..0x53FF stores the whole data byte into the register whose index is address bits 9:8. The program bank reflects the new value in the cycle after the write edge.
- R2: A CPU write whose address lies outside 0x5000..0x53FF changes no register. Both the program bank and the later character selection are unaffected by it.
- R3: The program bank equals the OR of three terms: register 2 bits 1:0 placed at bank bits 5:4, register 0 bits 3:0, and the outer bank input, which is already in 32 KB units.
- R4: When register 3 bit 2 is 0, program bank bits 1:0 are forced to 1. When that bit is 1, no bits are forced.
- R5: On a scanline strobe with register 0 bit 7 set and a line number below 239, both character bank outputs become 1 if the line is 127 or higher, and 0 if it is lower.
- R6: On a scanline strobe with register 0 bit 7 clear, or with a line number of 239 or more, the lower character output becomes 0 and the upper one becomes 1.
- R7: The character outputs change only at a strobe or a clear. A strobe uses the register 0 value from before any write in the same cycle.
- R8: The mirroring output is 1 (horizontal) when the outer configuration input is 1, and 0 (vertical) otherwise.
- R9: A mode clear sets all four registers to zero and returns the character outputs to 0 and 1. It takes priority over a CPU write or a strobe in the same cycle.
- R10: After reset the registers are zero and the character outputs are 0 (lower) and 1 (upper).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| mode_clear | input | 1 | Mode-activation clear request |
| line_strobe | input | 1 | Pulse at the start of each scanline |
| line_num | input | 9 | Number of the scanline that is starting |
| outer_bank | input | 6 | Outer program offset in 32 KB units |
| cfg_horiz | input | 1 | Outer configuration bit that selects horizontal mirroring |
| prg_bank | output | 6 | Selected 32 KB program bank |
| chr_lo_bank | output | 4 | 4 KB bank for the lower pattern half |
| chr_hi_bank | output | 4 | 4 KB bank for the upper pattern half |
| mirror_horiz | output | 1 | 1 for horizontal mirroring, 0 for vertical |

## Verification
Two events can fall in the same cycle: a CPU write that turns split mode on or off in register 0, and a scanline strobe. The bench provokes this by asserting the write and the strobe together on line 200. It then expects the character outputs to reflect the old register 0 value. On the next strobe alone it expects them to reflect the new value. A clear is also raised together with a write that sets bits in register 0. The program bank and a later strobe are then judged against an all-zero register file.

// File: rtl/nj_mapper_pkg.sv
// Package: shared widths, field positions and the character-pair rule.
// Assumes: registers are 8 bits wide and there are four of them.
package nj_mapper_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 4;
    localparam int SPLIT_BIT = 7;   // register 0: split-mode enable
    localparam int FILL_BIT  = 2;   // register 3: 0 forces bank bits 1:0

    typedef logic [REG_W-1:0] mreg_t;

    // Pair of 4 KB bank numbers for one scanline (lower half, upper half).
    typedef struct packed {
        logic [3:0] lo;
        logic [3:0] hi;
    } chr_pair_t;

    // Computes the character pair for a line given split enable and limits.
    function automatic chr_pair_t chr_pick(input logic split_en,
                                           input int   line,
                                           input int   split_line,
                                           input int   end_line);
        chr_pair_t p;
        if (split_en && line < end_line) begin
            p.lo = (line >= split_line) ? 4'd1 : 4'd0;
            p.hi = p.lo;
        end else begin
            p.lo = 4'd0;
            p.hi = 4'd1;
        end
        return p;
    endfunction
endpackage

// File: rtl/nj_regfile.sv
// Module: four-entry write-only register file behind an address window.
// Assumes: one write per cpu_wr pulse; mode_clear outranks any write.
module nj_regfile
    import nj_mapper_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] WIN_LO  = 16'h5000,
    parameter logic [15:0] WIN_HI  = 16'h53FF,
    parameter int          IDX_LSB = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_wr,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [REG_W-1:0]             cpu_data,
    input  logic                         mode_clear,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             in_win;
    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;

    // Decode the window and the target register index.
    always_comb begin
        in_win = (cpu_addr >= ADDR_W'(WIN_LO)) && (cpu_addr <= ADDR_W'(WIN_HI));
        wr_hit = cpu_wr && in_win;
        wr_idx = cpu_addr[IDX_LSB +: IDX_W];
    end

    // Hold the register contents; reset and clear zero them, a hit loads one entry.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_clear) begin
            regs_q <= '0;
        end else if (wr_hit) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_idx == IDX_W'(i)) regs_q[i] <= cpu_data;
            end
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clear |=> (regs_q == '0)); // R9
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !in_win && !mode_clear) |=> $stable(regs_q)); // R2
    AST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !mode_clear) |=> (regs_q[$past(wr_idx)] == $past(cpu_data))); // R1
endmodule

// File: rtl/nj_prg_map.sv
// Module: combinational 32 KB program bank former.
// Assumes: outer_bank is already in 32 KB units; PRG_W is at least 6.
module nj_prg_map #(
    parameter int PRG_W = 6
) (
    input  logic [3:0]       sel_lo,
    input  logic [1:0]       sel_hi,
    input  logic             keep_full,
    input  logic [PRG_W-1:0] outer_bank,
    output logic [PRG_W-1:0] prg_bank
);
    localparam logic [PRG_W-1:0] LOW_FILL = PRG_W'(3);

    // OR the register fields, the low fill and the outer offset together.
    always_comb begin
        prg_bank = PRG_W'({sel_hi, 4'b0000})
                 | PRG_W'(sel_lo)
                 | (keep_full ? '0 : LOW_FILL)
                 | outer_bank;
    end
endmodule

// File: rtl/nj_chr_sched.sv
// Module: per-scanline character bank selector with mid-frame split.
// Assumes: line_strobe pulses once at the start of each line, with line_num valid.
module nj_chr_sched
    import nj_mapper_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int SPLIT_LINE = 127,
    parameter int END_LINE   = 239,
    parameter int CHR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_clear,
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] line_num,
    input  logic              split_en,
    output logic [CHR_W-1:0]  chr_lo,
    output logic [CHR_W-1:0]  chr_hi
);
    chr_pair_t next_pair;

    // Work out the pair the current line asks for.
    always_comb begin
        next_pair = chr_pick(split_en, int'(line_num), SPLIT_LINE, END_LINE);
    end

    // Latch the pair at each strobe; reset and clear give the linear 8 KB layout.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_clear) begin
            chr_lo <= CHR_W'(0);
            chr_hi <= CHR_W'(1);
        end else if (line_strobe) begin
            chr_lo <= CHR_W'(next_pair.lo);
            chr_hi <= CHR_W'(next_pair.hi);
        end
    end

    AST_CHR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_strobe && !mode_clear) |=> ($stable(chr_lo) && $stable(chr_hi))); // R7
    AST_CHR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_lo == chr_hi) || (chr_lo == CHR_W'(0) && chr_hi == CHR_W'(1))); // R5
    AST_CHR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clear |=> (chr_lo == CHR_W'(0) && chr_hi == CHR_W'(1))); // R9
    AST_CHR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !mode_clear && !split_en) |=> (chr_lo == CHR_W'(0) && chr_hi == CHR_W'(1))); // R6
endmodule

// File: rtl/scanline_chr_mapper.sv
// Module: top of the mapper core; joins the register file, program bank former
// and per-line character selector. Assumes the outer board supplies a stable
// outer bank and mirroring bit, and that only this block owns the window.
module scanline_chr_mapper
    import nj_mapper_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int PRG_W      = 6,
    parameter int CHR_W      = 4,
    parameter int SPLIT_LINE = 127,
    parameter int END_LINE   = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              mode_clear,
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] line_num,
    input  logic [PRG_W-1:0]  outer_bank,
    input  logic              cfg_horiz,
    output logic [PRG_W-1:0]  prg_bank,
    output logic [CHR_W-1:0]  chr_lo_bank,
    output logic [CHR_W-1:0]  chr_hi_bank,
    output logic              mirror_horiz
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    nj_regfile #(
        .ADDR_W (16),
        .WIN_LO (16'h5000),
        .WIN_HI (16'h53FF),
        .IDX_LSB(8)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .mode_clear(mode_clear),
        .regs_q    (regs_q)
    );

    nj_prg_map #(.PRG_W(PRG_W)) u_prg (
        .sel_lo    (regs_q[0][3:0]),
        .sel_hi    (regs_q[2][1:0]),
        .keep_full (regs_q[3][FILL_BIT]),
        .outer_bank(outer_bank),
        .prg_bank  (prg_bank)
    );

    nj_chr_sched #(
        .LINE_W    (LINE_W),
        .SPLIT_LINE(SPLIT_LINE),
        .END_LINE  (END_LINE),
        .CHR_W     (CHR_W)
    ) u_chr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_clear (mode_clear),
        .line_strobe(line_strobe),
        .line_num   (line_num),
        .split_en   (regs_q[0][SPLIT_BIT]),
        .chr_lo     (chr_lo_bank),
        .chr_hi     (chr_hi_bank)
    );

    // Pass the outer mirroring choice straight through.
    always_comb mirror_horiz = cfg_horiz;

    AST_PRG_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q[3][FILL_BIT] |-> (prg_bank[1:0] == 2'b11)); // R4
    AST_PRG_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
        ((prg_bank & outer_bank) == outer_bank)); // R3
endmodule

// File: tb/scanline_chr_mapper_test.sv
`timescale 1ns/1ps
module scanline_chr_mapper_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_data = '0;
    logic       mode_clear = 1'b0;
    logic       line_strobe = 1'b0;
    logic [8:0] line_num = '0;
    logic [5:0] outer_bank = '0;
    logic       cfg_horiz = 1'b0;
    logic [5:0] prg_bank;
    logic [3:0] chr_lo_bank, chr_hi_bank;
    logic       mirror_horiz;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scanline_chr_mapper uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .mode_clear(mode_clear), .line_strobe(line_strobe),
        .line_num(line_num), .outer_bank(outer_bank), .cfg_horiz(cfg_horiz),
        .prg_bank(prg_bank), .chr_lo_bank(chr_lo_bank), .chr_hi_bank(chr_hi_bank),
        .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic strobe(input int ln);
        @(negedge clk);
        line_num = 9'(ln); line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
    endtask

    function automatic int exp_prg(int r0, int r2, int r3, int outer);
        return (((r2 & 3) << 4) | (r0 & 15) | (((r3 >> 2) & 1) != 0 ? 0 : 3) | outer) & 63;
    endfunction

    task automatic chk_chr(input string req, input bit en, input int ln);
        int lo, hi;
        if (en && ln < 239) begin lo = (ln >= 127) ? 1 : 0; hi = lo; end
        else begin lo = 0; hi = 1; end
        chk({req, " lo"}, int'(chr_lo_bank), lo);
        chk({req, " hi"}, int'(chr_hi_bank), hi);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state while reset is held
        chk("R10 prg", int'(prg_bank), 3);
        chk_chr("R10", 1'b0, 0);
        rst_n = 1'b1;

        // R1 R3 R4: exhaustive register-field sweep
        for (int r0 = 0; r0 < 16; r0++) begin
            for (int r2 = 0; r2 < 4; r2++) begin
                for (int f = 0; f < 2; f++) begin
                    wr(16'h5000 | 16'((r0 * 7) & 255), 8'(r0 | 16'h60));
                    wr(16'h5200 | 16'((r2 * 37) & 255), 8'(r2 | 8'hA8));
                    wr(16'h53FF, 8'(f != 0 ? 8'h04 : 8'hFB));
                    chk("R1 R3 R4 sweep", int'(prg_bank), exp_prg(r0, r2, f * 4, 0));
                end
            end
        end
        // R4: fill bit clear forces low bits with zero fields
        wr(16'h5000, 8'h00); wr(16'h5200, 8'h00); wr(16'h5300, 8'h00);
        chk("R4 fill", int'(prg_bank), 3);
        wr(16'h5300, 8'h04);
        chk("R4 no fill", int'(prg_bank), 0);

        // R3: outer offset sweep
        for (int o = 0; o < 64; o++) begin
            @(negedge clk); outer_bank = 6'(o); #1;
            chk("R3 outer", int'(prg_bank), o);
        end
        @(negedge clk); outer_bank = 6'd0;

        // R1: index 1 write does not alias other registers
        wr(16'h5100, 8'hFF);
        chk("R1 idx1", int'(prg_bank), 0);

        // R2: writes outside the window
        wr(16'h4FFF, 8'hFF); chk("R2 below", int'(prg_bank), 0);
        wr(16'h5400, 8'hFF); chk("R2 above", int'(prg_bank), 0);
        wr(16'h8000, 8'hFF); chk("R2 high", int'(prg_bank), 0);
        wr(16'hD300, 8'h00); chk("R2 idx3 alias", int'(prg_bank), 0);
        wr(16'h4F00, 8'h80);
        strobe(200);
        chk_chr("R2 split untouched", 1'b0, 200);

        // R8: mirroring
        @(negedge clk); cfg_horiz = 1'b1; #1;
        chk("R8 horiz", int'(mirror_horiz), 1);
        @(negedge clk); cfg_horiz = 1'b0; #1;
        chk("R8 vert", int'(mirror_horiz), 0);

        // R5 R6: every line with split on, then with split off
        wr(16'h5000, 8'h80);
        for (int ln = 0; ln < 512; ln++) begin
            strobe(ln);
            chk_chr(ln < 239 ? "R5 split" : "R6 bottom", 1'b1, ln);
        end
        wr(16'h5000, 8'h00);
        for (int ln = 0; ln < 512; ln++) begin
            strobe(ln);
            chk_chr("R6 off", 1'b0, ln);
        end

        // R7: no change without a strobe
        wr(16'h5000, 8'h80);
        strobe(200);
        @(negedge clk); line_num = 9'd10;
        repeat (4) @(negedge clk);
        chk_chr("R7 line move", 1'b1, 200);
        wr(16'h5000, 8'h00);
        chk_chr("R7 reg write", 1'b1, 200);
        // R7: same-cycle write and strobe uses old register 0
        strobe(200);
        chk_chr("R7 baseline", 1'b0, 200);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'h5000; cpu_data = 8'h80;
        line_num = 9'd200; line_strobe = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; line_strobe = 1'b0;
        chk_chr("R7 same cycle old", 1'b0, 200);
        strobe(200);
        chk_chr("R7 next strobe new", 1'b1, 200);

        // R9: clear beats a same-cycle write
        wr(16'h5200, 8'h03);
        @(negedge clk);
        mode_clear = 1'b1; cpu_wr = 1'b1; cpu_addr = 16'h5000; cpu_data = 8'h8F;
        @(negedge clk);
        mode_clear = 1'b0; cpu_wr = 1'b0;
        chk("R9 prg", int'(prg_bank), 3);
        chk_chr("R9 chr", 1'b0, 200);
        strobe(200);
        chk_chr("R9 split cleared", 1'b0, 200);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule